// File: doc/BRIEF.md
# Global-Snoop Coherency Controller

This block keeps a small write-back data cache consistent with a second bus master, such as a DMA engine, that shares the system bus. It holds the tag and line-state array of a direct-mapped cache with 16 sets and 32-byte lines. It watches the other master's transactions. It only acts on a transaction whose global flag is set. If the line is clean, a hit removes it quietly. If the line is modified, the hit aborts the transaction with a retry. The controller then copies the line out to memory through a request/acknowledge handshake and drops it. After that, the other master's repeated access misses and goes through.

Software can also send two maintenance commands for an address. Flush copies the line out if it is modified, then drops it. Invalidate drops the line and never copies it out. The CPU side installs lines and marks them modified through a fill port. It can read a line's state through a read port. The data array and any eviction traffic caused by fills belong to the surrounding cache and are not part of this block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every line reads as invalid (`rd_state` = 2'b00). After reset, `wb_req` and `snp_retry` are low.
- R2: A fill stores the address's tag in its set. It sets the state to clean (2'b01) if `fill_dirty` is 0, or modified (2'b11) if it is 1. The new state shows on `rd_state` from the next cycle. `rd_state` reads 2'b00 when the set's tag differs from `rd_addr`. A fill to the set under write-back is ignored. A fill also loses to an invalidation of the same set in the same cycle.
- R3: A snoop with `snp_global` low never asserts `snp_retry` and changes no line state.
- R4: A global snoop that misses, or that matches an invalid line, asserts no retry and changes no state.
- R5: A global snoop hitting a clean line asserts no retry. The line reads invalid from the next cycle.
- R6: A global snoop hitting a modified line asserts `snp_retry` in the same cycle. `wb_req` rises in the next cycle, with `wb_addr` set to the line address (low 5 bits zero).
- R7: `wb_req` and `wb_addr` hold until `wb_ack` is sampled high. Until then, global snoops to that line keep getting a retry. In the cycle after the acknowledge, `wb_req` is low and the line is invalid, so the repeated snoop gets no retry.
- R8: Lines are matched on address bits above the 5-bit byte offset. Addresses that differ only in bits [4:0] match the same line. The same set with a different tag is a miss.
- R9: A flush of a modified line raises `wb_req` for that line in the cycle after acceptance, and leaves the line invalid after `wb_ack`. A flush of a clean line invalidates it with no `wb_req`.
- R10: An invalidate command (`cmd_op` = 1; flush is 0) removes the line even when it is modified, and never raises `wb_req`.
- R11: `cmd_ready` is low while a global snoop is presented or a write-back is in progress. A command takes effect only at an edge where `cmd_valid` and `cmd_ready` are both high.
- R12: During a write-back, a global snoop that hits another modified line gets a retry but starts no second write-back. `wb_addr` keeps the first line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_en | input | 1 | CPU side installs or marks a line |
| fill_addr | input | 32 | Byte address of the filled line |
| fill_dirty | input | 1 | 1 = line modified, 0 = clean |
| rd_addr | input | 32 | Byte address to query |
| rd_state | output | 2 | State of the queried line (00 invalid, 01 clean, 11 modified) |
| snp_valid | input | 1 | Other master's bus transaction present |
| snp_global | input | 1 | Transaction carries the global attribute |
| snp_addr | input | 32 | Byte address of the snooped transaction |
| snp_retry | output | 1 | Abort the snooped transaction (same cycle) |
| cmd_valid | input | 1 | Maintenance command present |
| cmd_op | input | 1 | 0 = flush, 1 = invalidate |
| cmd_addr | input | 32 | Byte address for the command |
| cmd_ready | output | 1 | Command accepted this cycle |
| wb_req | output | 1 | Write-back request to memory |
| wb_addr | output | 32 | Line address being written back |
| wb_ack | input | 1 | Memory has taken the write-back |

## Verification
The assertions assume three things about the inputs. `wb_ack` is only pulsed while `wb_req` is high. `cmd_valid` and its fields stay put until `cmd_ready` is seen. Snoop inputs are stable for the whole cycle, since `snp_retry` depends on them combinationally. The bench drives every input on the falling edge. It raises the acknowledge only in cycles where it has already seen `wb_req` high. It holds a command until its acceptance has been checked. It never issues a fill that collides with a same-set invalidation, so the priority rule between them never decides a checked result.

// File: rtl/coh_pkg.sv
// Shared types for the snooping coherency controller.
// Assumes two-bit line state and a single-bit command opcode.
package coh_pkg;
    typedef enum logic [1:0] {
        LS_INV   = 2'b00,
        LS_CLEAN = 2'b01,
        LS_DIRTY = 2'b11
    } line_st_e;

    typedef enum logic {
        OP_FLUSH = 1'b0,
        OP_INVAL = 1'b1
    } cmd_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WB   = 1'b1
    } wb_fsm_e;
endpackage

// File: rtl/coh_tag_array.sv
// Direct-mapped tag and line-state storage with three combinational read
// ports and per-set update logic. Any invalidation aimed at a set wins
// over a fill of that set in the same cycle. Tags are not reset; only
// the state is, which is enough to make every line a miss.
module coh_tag_array
    import coh_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS),
    parameter int TAG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    // read port A (snoop), B (command), C (query)
    input  logic [IDX_W-1:0] ra_idx,
    output logic [TAG_W-1:0] ra_tag,
    output line_st_e         ra_st,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [TAG_W-1:0] rb_tag,
    output line_st_e         rb_st,
    input  logic [IDX_W-1:0] rc_idx,
    output logic [TAG_W-1:0] rc_tag,
    output line_st_e         rc_st,
    // invalidation requests
    input  logic             inv_a_en,
    input  logic [IDX_W-1:0] inv_a_idx,
    input  logic             inv_b_en,
    input  logic [IDX_W-1:0] inv_b_idx,
    input  logic             inv_c_en,
    input  logic [IDX_W-1:0] inv_c_idx,
    // fill write
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_st_e         wr_st
);
    logic [SETS-1:0][1:0]       st_vec;
    logic [SETS-1:0][TAG_W-1:0] tag_vec;

    for (genvar g = 0; g < SETS; g++) begin : g_set
        line_st_e         st_q;
        logic [TAG_W-1:0] tag_q;
        logic             kill;
        logic             load;

        assign kill = (inv_a_en && inv_a_idx == IDX_W'(g)) ||
                      (inv_b_en && inv_b_idx == IDX_W'(g)) ||
                      (inv_c_en && inv_c_idx == IDX_W'(g));
        assign load = wr_en && (wr_idx == IDX_W'(g));

        // Per-set state update: reset, then invalidate, then fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= LS_INV;
            end else if (kill) begin
                st_q <= LS_INV;
            end else if (load) begin
                st_q  <= wr_st;
                tag_q <= wr_tag;
            end
        end

        assign st_vec[g]  = st_q;
        assign tag_vec[g] = tag_q;
    end

    assign ra_st  = line_st_e'(st_vec[ra_idx]);
    assign ra_tag = tag_vec[ra_idx];
    assign rb_st  = line_st_e'(st_vec[rb_idx]);
    assign rb_tag = tag_vec[rb_idx];
    assign rc_st  = line_st_e'(st_vec[rc_idx]);
    assign rc_tag = tag_vec[rc_idx];
endmodule

// File: rtl/coh_ctrl_fsm.sv
// Snoop response and write-back sequencer. Decides retry and quiet
// invalidation for global snoops, accepts maintenance commands when no
// snoop is present and no write-back is running, and holds one
// write-back line until memory acknowledges it.
// Assumes hit/dirty inputs come from the current tag array contents.
module coh_ctrl_fsm
    import coh_pkg::*;
#(
    parameter int LINE_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_act,
    input  logic              snp_hit,
    input  logic              snp_dirty,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              cmd_valid,
    input  logic              cmd_flush,
    input  logic              cmd_hit,
    input  logic              cmd_dirty,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic              wb_ack,
    output logic              snp_retry,
    output logic              snp_inv,
    output logic              cmd_ready,
    output logic              cmd_inv,
    output logic              wb_req,
    output logic [LINE_W-1:0] wb_line,
    output logic              wb_done
);
    wb_fsm_e           state_q;
    logic [LINE_W-1:0] line_q;
    logic              busy;
    logic              cmd_go;
    logic              cmd_wb;
    logic              start_wb;

    // Combinational snoop and command decisions.
    always_comb begin
        busy      = (state_q == S_WB);
        snp_retry = snp_act && snp_hit && snp_dirty;
        snp_inv   = snp_act && snp_hit && !snp_dirty;
        cmd_ready = !busy && !snp_act;
        cmd_go    = cmd_valid && cmd_ready;
        cmd_wb    = cmd_go && cmd_flush && cmd_hit && cmd_dirty;
        cmd_inv   = cmd_go && cmd_hit && !cmd_wb;
        start_wb  = (!busy && snp_retry) || cmd_wb;
        wb_done   = busy && wb_ack;
    end

    // Write-back state and captured line address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            line_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start_wb) begin
                    state_q <= S_WB;
                    line_q  <= snp_retry ? snp_line : cmd_line;
                end
                S_WB: if (wb_ack) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign wb_req  = busy;
    assign wb_line = line_q;
endmodule

// File: rtl/snoop_coh_ctrl.sv
// Top of the snooping coherency controller: splits addresses into
// tag/index/offset, looks up the tag array for snoop, command and query,
// and routes invalidations and fills. Assumes a direct-mapped cache and
// that eviction caused by fills is handled outside this block.
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_state,
    input  logic              snp_valid,
    input  logic              snp_global,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int LINE_W = ADDR_W - OFFS_W;
    localparam int TAG_W  = LINE_W - IDX_W;

    logic [LINE_W-1:0] snp_line, cmd_line, rd_line, fill_line, wb_line;
    logic [TAG_W-1:0]  snp_tag_q, cmd_tag_q, rd_tag_q;
    line_st_e          snp_st, cmd_st, rd_st;
    logic              snp_hit, cmd_hit, rd_hit;
    logic              snp_inv, cmd_inv, wb_done;
    logic              fill_ok;
    logic              unused_offs;

    assign snp_line  = snp_addr[ADDR_W-1:OFFS_W];
    assign cmd_line  = cmd_addr[ADDR_W-1:OFFS_W];
    assign rd_line   = rd_addr[ADDR_W-1:OFFS_W];
    assign fill_line = fill_addr[ADDR_W-1:OFFS_W];
    assign unused_offs = ^{snp_addr[OFFS_W-1:0], cmd_addr[OFFS_W-1:0],
                           rd_addr[OFFS_W-1:0], fill_addr[OFFS_W-1:0]};

    // Tag compare for the three lookups.
    always_comb begin
        snp_hit = (snp_st != LS_INV) && (snp_tag_q == snp_line[LINE_W-1:IDX_W]);
        cmd_hit = (cmd_st != LS_INV) && (cmd_tag_q == cmd_line[LINE_W-1:IDX_W]);
        rd_hit  = (rd_st  != LS_INV) && (rd_tag_q  == rd_line[LINE_W-1:IDX_W]);
        rd_state = rd_hit ? rd_st : LS_INV;
        fill_ok = fill_en &&
                  !(wb_req && fill_line[IDX_W-1:0] == wb_line[IDX_W-1:0]);
    end

    coh_tag_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_idx    (snp_line[IDX_W-1:0]),
        .ra_tag    (snp_tag_q),
        .ra_st     (snp_st),
        .rb_idx    (cmd_line[IDX_W-1:0]),
        .rb_tag    (cmd_tag_q),
        .rb_st     (cmd_st),
        .rc_idx    (rd_line[IDX_W-1:0]),
        .rc_tag    (rd_tag_q),
        .rc_st     (rd_st),
        .inv_a_en  (snp_inv),
        .inv_a_idx (snp_line[IDX_W-1:0]),
        .inv_b_en  (cmd_inv),
        .inv_b_idx (cmd_line[IDX_W-1:0]),
        .inv_c_en  (wb_done),
        .inv_c_idx (wb_line[IDX_W-1:0]),
        .wr_en     (fill_ok),
        .wr_idx    (fill_line[IDX_W-1:0]),
        .wr_tag    (fill_line[LINE_W-1:IDX_W]),
        .wr_st     (fill_dirty ? LS_DIRTY : LS_CLEAN)
    );

    coh_ctrl_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_act   (snp_valid && snp_global),
        .snp_hit   (snp_hit),
        .snp_dirty (snp_st == LS_DIRTY),
        .snp_line  (snp_line),
        .cmd_valid (cmd_valid),
        .cmd_flush (cmd_op == OP_FLUSH),
        .cmd_hit   (cmd_hit),
        .cmd_dirty (cmd_st == LS_DIRTY),
        .cmd_line  (cmd_line),
        .wb_ack    (wb_ack),
        .snp_retry (snp_retry),
        .snp_inv   (snp_inv),
        .cmd_ready (cmd_ready),
        .cmd_inv   (cmd_inv),
        .wb_req    (wb_req),
        .wb_line   (wb_line),
        .wb_done   (wb_done)
    );

    assign wb_addr = {wb_line, {OFFS_W{1'b0}}};
endmodule

// File: rtl/coh_chk.sv
// Protocol checker for snoop_coh_ctrl, attached by bind below.
// Assumes wb_ack is only pulsed while wb_req is high.
module coh_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snp_valid,
    input logic              snp_global,
    input logic              snp_retry,
    input logic              cmd_valid,
    input logic              cmd_op,
    input logic              cmd_ready,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr
);
    // R3
    nonglobal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_global) |-> !snp_retry);

    // R6
    retry_starts_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_retry && !wb_req) |=> wb_req);

    // R7
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R7
    wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> !wb_req);

    // R10
    inval_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op) |=> !wb_req);

    // R11
    busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !cmd_ready);
endmodule

bind snoop_coh_ctrl coh_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_global (snp_global),
    .snp_retry  (snp_retry),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_ready  (cmd_ready),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .wb_addr    (wb_addr)
);

// File: tb/sim_snoop_coh_ctrl.sv
// Self-checking bench: vector table for fills and simple snoops, then
// directed write-back, command and reset cases.
module sim_snoop_coh_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fill_en, fill_dirty;
    logic [31:0] fill_addr, rd_addr, snp_addr, cmd_addr;
    logic [1:0]  rd_state;
    logic        snp_valid, snp_global, snp_retry;
    logic        cmd_valid, cmd_op, cmd_ready;
    logic        wb_req, wb_ack;
    logic [31:0] wb_addr;

    int n_run  = 0;
    int n_fail = 0;
    logic [37:0] v;

    always #2.5 clk = ~clk;

    snoop_coh_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .rd_addr(rd_addr), .rd_state(rd_state),
        .snp_valid(snp_valid), .snp_global(snp_global), .snp_addr(snp_addr),
        .snp_retry(snp_retry),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
    );

    // op: 0 fill, 1 global snoop, 2 non-global snoop, 3 read only
    // fields: op[37:36] addr[35:4] dirty[3] exp_retry[2] exp_state[1:0]
    localparam int NVEC = 12;
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd0, 32'h0000_1020, 1'b0, 1'b0, 2'b01},  // R2 clean fill
        {2'd0, 32'h0000_2043, 1'b1, 1'b0, 2'b11},  // R2 dirty fill
        {2'd2, 32'h0000_1020, 1'b0, 1'b0, 2'b01},  // R3 non-global on clean
        {2'd2, 32'h0000_2040, 1'b0, 1'b0, 2'b11},  // R3 non-global on dirty
        {2'd1, 32'h0000_3020, 1'b0, 1'b0, 2'b00},  // R8 same set other tag
        {2'd3, 32'h0000_1020, 1'b0, 1'b0, 2'b01},  // R4 miss left line alone
        {2'd1, 32'h0000_5000, 1'b0, 1'b0, 2'b00},  // R4 invalid set
        {2'd0, 32'h0000_1020, 1'b1, 1'b0, 2'b11},  // R2 mark dirty
        {2'd0, 32'h0000_1020, 1'b0, 1'b0, 2'b01},  // R2 back to clean
        {2'd0, 32'h0000_5000, 1'b0, 1'b0, 2'b01},  // R2 clean fill set 0
        {2'd1, 32'h0000_501F, 1'b0, 1'b0, 2'b00},  // R5 clean hit, R8 offset
        {2'd1, 32'h0000_5000, 1'b0, 1'b0, 2'b00}   // R4 now invalid
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        fill_en = 0; fill_dirty = 0; fill_addr = '0;
        snp_valid = 0; snp_global = 0; snp_addr = '0;
        cmd_valid = 0; cmd_op = 0; cmd_addr = '0;
        wb_ack = 0;
    endtask

    task automatic snoop_g(input logic [31:0] a);
        snp_valid = 1; snp_global = 1; snp_addr = a;
    endtask

    task automatic read_chk(input string req, input logic [31:0] a,
                            input logic [1:0] exp);
        rd_addr = a;
        #0.5;
        check(req, {30'd0, rd_state}, {30'd0, exp});
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        quiet();
        rd_addr = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int s = 0; s < 16; s++) read_chk("R1 set state", 32'(s) << 5, 2'b00);
        check("R1 wb_req", {31'd0, wb_req}, 32'd0);
        check("R1 retry", {31'd0, snp_retry}, 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            @(negedge clk);
            quiet();
            case (v[37:36])
                2'd0: begin fill_en = 1; fill_addr = v[35:4]; fill_dirty = v[3]; end
                2'd1: snoop_g(v[35:4]);
                2'd2: begin snp_valid = 1; snp_global = 0; snp_addr = v[35:4]; end
                default: ;
            endcase
            #1;
            if (v[37:36] == 2'd1) check("R4/R5 table retry", {31'd0, snp_retry}, {31'd0, v[2]});
            if (v[37:36] == 2'd2) check("R3 table retry", {31'd0, snp_retry}, {31'd0, v[2]});
            @(negedge clk);
            quiet();
            read_chk("R2/R3/R4/R5 table state", v[35:4], v[1:0]);
        end

        // Second dirty line for R12 and flush
        @(negedge clk); quiet();
        fill_en = 1; fill_addr = 32'h0000_4060; fill_dirty = 1;

        // R6 dirty hit: retry now, write-back next cycle
        @(negedge clk); quiet();
        snoop_g(32'h0000_2048);
        #1;
        check("R6 retry on dirty hit", {31'd0, snp_retry}, 32'd1);
        check("R6 no wb yet", {31'd0, wb_req}, 32'd0);
        @(negedge clk); quiet();
        snoop_g(32'h0000_2040);
        cmd_valid = 1; cmd_op = 1; cmd_addr = 32'h0000_1020;
        fill_en = 1; fill_addr = 32'h0000_2040; fill_dirty = 0;
        #1;
        check("R6 wb_req", {31'd0, wb_req}, 32'd1);
        check("R6 wb_addr", wb_addr, 32'h0000_2040);
        check("R7 retry while busy", {31'd0, snp_retry}, 32'd1);
        check("R11 ready low while busy", {31'd0, cmd_ready}, 32'd0);
        @(negedge clk); quiet();
        snoop_g(32'h0000_4060);
        #1;
        check("R12 retry other dirty line", {31'd0, snp_retry}, 32'd1);
        read_chk("R2 fill to busy set ignored", 32'h0000_2040, 2'b11);
        @(negedge clk); quiet();
        wb_ack = 1;
        #1;
        check("R7 wb held until ack", {31'd0, wb_req}, 32'd1);
        check("R12 wb_addr kept", wb_addr, 32'h0000_2040);
        @(negedge clk); quiet();
        #1;
        check("R7 wb_req released", {31'd0, wb_req}, 32'd0);
        read_chk("R7 line invalid after ack", 32'h0000_2040, 2'b00);
        read_chk("R11 blocked command not taken", 32'h0000_1020, 2'b01);
        @(negedge clk); quiet();
        snoop_g(32'h0000_2040);
        #1;
        check("R7 rerun no retry", {31'd0, snp_retry}, 32'd0);
        check("R12 no second wb", {31'd0, wb_req}, 32'd0);
        read_chk("R12 other line still dirty", 32'h0000_4060, 2'b11);

        // R9 flush of dirty line
        @(negedge clk); quiet();
        cmd_valid = 1; cmd_op = 0; cmd_addr = 32'h0000_4064;
        #1;
        check("R11 ready when idle", {31'd0, cmd_ready}, 32'd1);
        @(negedge clk); quiet();
        #1;
        check("R9 flush wb_req", {31'd0, wb_req}, 32'd1);
        check("R9 flush wb_addr", wb_addr, 32'h0000_4060);
        @(negedge clk);
        #1;
        check("R9 flush wb held", {31'd0, wb_req}, 32'd1);
        wb_ack = 1;
        @(negedge clk); quiet();
        #1;
        check("R9 flush done", {31'd0, wb_req}, 32'd0);
        read_chk("R9 flushed line invalid", 32'h0000_4060, 2'b00);

        // R9 flush of clean line
        @(negedge clk); quiet();
        cmd_valid = 1; cmd_op = 0; cmd_addr = 32'h0000_1020;
        @(negedge clk); quiet();
        #1;
        check("R9 clean flush no wb", {31'd0, wb_req}, 32'd0);
        read_chk("R9 clean flush invalid", 32'h0000_1020, 2'b00);

        // R10 invalidate of dirty line
        @(negedge clk); quiet();
        fill_en = 1; fill_addr = 32'h0000_6080; fill_dirty = 1;
        @(negedge clk); quiet();
        cmd_valid = 1; cmd_op = 1; cmd_addr = 32'h0000_6080;
        @(negedge clk); quiet();
        #1;
        check("R10 no wb on invalidate", {31'd0, wb_req}, 32'd0);
        read_chk("R10 dirty line discarded", 32'h0000_6080, 2'b00);

        // R11 command waits behind a same-cycle snoop
        @(negedge clk); quiet();
        fill_en = 1; fill_addr = 32'h0000_70A0; fill_dirty = 0;
        @(negedge clk); quiet();
        cmd_valid = 1; cmd_op = 1; cmd_addr = 32'h0000_70A0;
        snoop_g(32'h0000_0000);
        #1;
        check("R11 ready low with snoop", {31'd0, cmd_ready}, 32'd0);
        check("R4 miss no retry", {31'd0, snp_retry}, 32'd0);
        @(negedge clk);
        snp_valid = 0; snp_global = 0;
        read_chk("R11 command deferred", 32'h0000_70A0, 2'b01);
        check("R11 ready after snoop", {31'd0, cmd_ready}, 32'd1);
        @(negedge clk); quiet();
        read_chk("R11 command applied", 32'h0000_70A0, 2'b00);

        // R1 reset mid-run
        @(negedge clk); quiet();
        fill_en = 1; fill_addr = 32'h0000_2040; fill_dirty = 1;
        @(negedge clk); quiet();
        read_chk("R2 refill dirty", 32'h0000_2040, 2'b11);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        read_chk("R1 reset clears line", 32'h0000_2040, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule